// File: doc/BRIEF.md
# Indexed Effective-Address Generator with Fix-Up Cycle Reporting

This block forms the effective address of an indexed memory access for an 8-bit processor with a 16-bit address space. A request carries an addressing mode, an access kind and the operand bytes. For the indirect mode the operand is a page-zero pointer. The block fetches the two base bytes through a small request/acknowledge memory port. It then adds the selected index register and presents the result on an address output, one or two beats long.

Each address beat also carries two flags. One reports a penalty cycle caused by crossing a 256-byte page. The other reports the cycle adjustment the instruction sequencer should add. Reads pay the extra cycle only when the index carries out of the low address byte. When that happens they first show the address with the stale high byte and then the corrected one. Writes and read-modify-writes always pay the fix-up cycle but show only the corrected address. Page-zero indexed modes wrap inside page zero and never pay extra.

Top module: `idx_agen`

## Requirements
- R1: Absolute modes (mode 0 uses index X, mode 1 uses index Y) produce base + index modulo 2^16. For example, base $FFFF plus 1 gives $0000.
- R2: An absolute or indirect read (kind 0) whose sum changes the high byte produces two beats. The first beat shows {base high byte, summed low byte} with addr_last=0. On the next cycle the second beat shows the full sum with addr_last=1. Both beats carry page_pen=1 and cyc_adj=1.
- R3: A read whose sum keeps the base high byte produces one beat with addr_last=1, page_pen=0 and cyc_adj=0.
- R4: Page-zero modes (mode 2 uses X, mode 3 uses Y) ignore the operand high byte. They produce {$00, (low byte + index) mod 256} in one beat with page_pen=0 and cyc_adj=0 for every kind.
- R5: Indirect mode (mode 4, index Y) first reads the low base byte at {$00, pointer}, then the high base byte at {$00, (pointer+1) mod 256}. It then adds Y to the 16-bit base.
- R6: An indirect read that carries out of the low byte takes the penalty with the same two-beat behaviour as R2.
- R7: Writes (kind 1) and read-modify-writes (kind 2) in absolute and indirect modes produce one corrected beat with page_pen=0 and cyc_adj=1.
- R8: mem_req stays high with a stable mem_addr until mem_ack is seen. Each pointer byte needs its own request/acknowledge exchange.
- R9: After reset the block is idle with addr_vld, mem_req and busy low. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| mode | input | 3 | Addressing mode code (0..4) |
| kind | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write |
| base | input | 16 | Absolute base, or page-zero operand/pointer in the low byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| busy | output | 1 | Request in progress |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Read acknowledge |
| addr_vld | output | 1 | Address beat present |
| addr_last | output | 1 | Beat is the final, corrected address |
| eff_addr | output | 16 | Presented address |
| page_pen | output | 1 | Page-cross penalty taken |
| cyc_adj | output | 1 | Cycles to add to the base count |

## Verification
The assertions assume that the memory side answers each request at most once, and only while mem_req is high. They also assume that mode and kind hold legal codes when start is accepted. The bench memory model raises mem_ack for exactly one cycle after it sees a pending request, and it returns bytes from a page-zero array it owns. The driver only issues codes 0 to 4 for mode and 0 to 2 for kind. It waits for busy to fall before a new request, except for one deliberate start pulse during a busy interval that tests R9.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  localparam logic [2:0] AM_ABS_X = 3'd0;
  localparam logic [2:0] AM_ABS_Y = 3'd1;
  localparam logic [2:0] AM_ZP_X  = 3'd2;
  localparam logic [2:0] AM_ZP_Y  = 3'd3;
  localparam logic [2:0] AM_IND_Y = 3'd4;

  localparam logic [1:0] AK_READ  = 2'd0;
  localparam logic [1:0] AK_WRITE = 2'd1;
  localparam logic [1:0] AK_RMW   = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ADDR, ST_FIX} agen_st_e;
  typedef enum logic [1:0] {PF_IDLE, PF_LO, PF_HI} fetch_st_e;
endpackage

// File: rtl/idx_agen_rst_sync.sv
module idx_agen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/idx_agen_sum.sv
module idx_agen_sum #(
  parameter int DW = 8
) (
  input  logic            zp_mode,
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  output logic [2*DW-1:0] sum,
  output logic [2*DW-1:0] stale,
  output logic            carry
);
  logic [DW:0]   lo_ext;
  logic [DW-1:0] hi_inc;

  always_comb begin
    lo_ext = {1'b0, base[DW-1:0]} + {1'b0, idx};
    hi_inc = base[2*DW-1:DW] + {{(DW-1){1'b0}}, lo_ext[DW]};
    if (zp_mode) begin
      sum   = {{DW{1'b0}}, lo_ext[DW-1:0]};
      stale = {{DW{1'b0}}, lo_ext[DW-1:0]};
      carry = 1'b0;
    end else begin
      sum   = {hi_inc, lo_ext[DW-1:0]};
      stale = {base[2*DW-1:DW], lo_ext[DW-1:0]};
      carry = lo_ext[DW];
    end
  end
endmodule

// File: rtl/idx_agen_fetch.sv
module idx_agen_fetch
  import idx_agen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [DW-1:0]   ptr,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            done,
  output logic [2*DW-1:0] base_out
);
  fetch_st_e     st_q, st_d;
  logic [DW-1:0] ptr_q, lo_q;
  logic          ptr_en, lo_en;

  always_comb begin
    st_d   = st_q;
    ptr_en = 1'b0;
    lo_en  = 1'b0;
    done   = 1'b0;
    case (st_q)
      PF_IDLE: if (go) begin st_d = PF_LO; ptr_en = 1'b1; end
      PF_LO:   if (mem_ack) begin st_d = PF_HI; lo_en = 1'b1; end
      PF_HI:   if (mem_ack) begin st_d = PF_IDLE; done = 1'b1; end
      default: st_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PF_IDLE;
      ptr_q <= '0;
      lo_q  <= '0;
    end else begin
      st_q <= st_d;
      if (ptr_en) ptr_q <= ptr;
      if (lo_en)  lo_q  <= mem_rdata;
    end
  end

  assign mem_req  = (st_q == PF_LO) || (st_q == PF_HI);
  assign mem_addr = {{DW{1'b0}}, (st_q == PF_HI) ? ptr_q + 1'b1 : ptr_q};
  assign base_out = {mem_rdata, lo_q};

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_ptr_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2*DW-1:DW] == '0);
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [1:0]      kind,
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  output logic            busy,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            addr_vld,
  output logic            addr_last,
  output logic [2*DW-1:0] eff_addr,
  output logic            page_pen,
  output logic            cyc_adj
);
  localparam int AW = 2 * DW;

  logic          rst_s_n;
  agen_st_e      st_q, st_d;
  logic [2:0]    mode_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] base_q, base_d;
  logic [DW-1:0] idx_q;
  logic          cap_en, base_en, fetch_go, fetch_done;
  logic [AW-1:0] fetch_base, sum_w, stale_w;
  logic          carry_w, zp_q, read_q, pen_w;

  idx_agen_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  idx_agen_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_s_n), .go(fetch_go), .ptr(base[DW-1:0]),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(fetch_done), .base_out(fetch_base));

  assign zp_q   = (mode_q == AM_ZP_X) || (mode_q == AM_ZP_Y);
  assign read_q = (kind_q == AK_READ);

  idx_agen_sum #(.DW(DW)) u_sum (
    .zp_mode(zp_q), .base(base_q), .idx(idx_q),
    .sum(sum_w), .stale(stale_w), .carry(carry_w));

  assign pen_w = read_q && carry_w;

  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    base_en  = 1'b0;
    base_d   = base_q;
    fetch_go = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        cap_en  = 1'b1;
        base_en = 1'b1;
        if (mode == AM_IND_Y) begin
          st_d     = ST_FETCH;
          fetch_go = 1'b1;
          base_d   = '0;
        end else begin
          st_d   = ST_ADDR;
          base_d = base;
        end
      end
      ST_FETCH: if (fetch_done) begin
        st_d    = ST_ADDR;
        base_en = 1'b1;
        base_d  = fetch_base;
      end
      ST_ADDR: st_d = pen_w ? ST_FIX : ST_IDLE;
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_ABS_X;
      kind_q <= AK_READ;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        mode_q <= mode;
        kind_q <= kind;
        idx_q  <= (mode == AM_ABS_Y || mode == AM_ZP_Y || mode == AM_IND_Y)
                  ? idx_y : idx_x;
      end
      if (base_en) base_q <= base_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign addr_vld  = (st_q == ST_ADDR) || (st_q == ST_FIX);
  assign addr_last = (st_q == ST_FIX) || ((st_q == ST_ADDR) && !pen_w);
  assign eff_addr  = !addr_vld ? '0 :
                     ((st_q == ST_ADDR) && pen_w) ? stale_w : sum_w;
  assign page_pen  = addr_vld && pen_w;
  assign cyc_adj   = addr_vld && !zp_q && (read_q ? carry_w : 1'b1);

  assert_zp_wrap_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_vld && zp_q |-> eff_addr[AW-1:DW] == '0 && !page_pen && !cyc_adj);
  assert_fix_follows_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_vld && !addr_last |=> addr_vld && addr_last &&
      eff_addr[DW-1:0] == $past(eff_addr[DW-1:0]) &&
      eff_addr[AW-1:DW] == $past(eff_addr[AW-1:DW]) + 1'b1);
  assert_no_write_pen_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    addr_vld && !read_q && !zp_q |-> addr_last && !page_pen && cyc_adj);
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy && start |=> $stable(mode_q) && $stable(kind_q));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> !addr_vld && !mem_req);
endmodule

// File: tb/sim_idx_agen.sv
`timescale 1ns/1ps
module sim_idx_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  kind = '0;
  logic [15:0] base = '0;
  logic [7:0]  idx_x = '0, idx_y = '0;
  logic        busy, mem_req, addr_vld, addr_last, page_pen, cyc_adj;
  logic [15:0] mem_addr, eff_addr;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  zp_mem [256];
  logic [18:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  idx_agen u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .kind(kind),
    .base(base), .idx_x(idx_x), .idx_y(idx_y), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .addr_vld(addr_vld), .addr_last(addr_last), .eff_addr(eff_addr),
    .page_pen(page_pen), .cyc_adj(cyc_adj));

  always_ff @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= zp_mem[mem_addr[7:0]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [18:0] act,
                       input logic [18:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected beat per presented address
  logic        prev_req = 1'b0, prev_ack = 1'b0;
  logic [15:0] prev_addr = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && addr_vld) begin
        logic [18:0] act;
        act = {eff_addr, addr_last, page_pen, cyc_adj};
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected beat", act, '0);
        else begin
          logic [18:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(act == e, t, act, e);
        end
      end
      if (rst_n && prev_req && !prev_ack)
        check(mem_req && mem_addr == prev_addr, "R8 request hold",
              {3'b0, mem_addr}, {3'b0, prev_addr});
      if (rst_n && mem_req)
        check(mem_addr[15:8] == 8'h00, "R5 pointer in page zero",
              {3'b0, mem_addr}, {11'b0, mem_addr[7:0]});
      prev_req = mem_req;
      prev_ack = mem_ack;
      prev_addr = mem_addr;
    end
  end

  // Driver: computes expected beats from the requirements, then issues
  task automatic run(input logic [2:0] m, input logic [1:0] k, input logic [15:0] b,
                     input logic [7:0] x, input logic [7:0] y, input string tag,
                     input bit poke_busy);
    logic [7:0]  ix;
    logic [15:0] bb, ea;
    ix = (m == 3'd1 || m == 3'd3 || m == 3'd4) ? y : x;
    if (m == 3'd2 || m == 3'd3) begin
      ea = {8'h00, b[7:0] + ix};
      exp_q.push_back({ea, 3'b100}); tag_q.push_back(tag);
    end else begin
      bb = (m == 3'd4) ? {zp_mem[b[7:0] + 8'd1], zp_mem[b[7:0]]} : b;
      ea = bb + {8'h00, ix};
      if (k != 2'd0) begin
        exp_q.push_back({ea, 3'b101}); tag_q.push_back(tag);
      end else if (ea[15:8] != bb[15:8]) begin
        exp_q.push_back({bb[15:8], ea[7:0], 3'b011}); tag_q.push_back(tag);
        exp_q.push_back({ea, 3'b111}); tag_q.push_back(tag);
      end else begin
        exp_q.push_back({ea, 3'b100}); tag_q.push_back(tag);
      end
    end
    @(posedge clk); #1;
    start = 1'b1; mode = m; kind = k; base = b; idx_x = x; idx_y = y;
    @(posedge clk); #1;
    if (poke_busy) begin
      mode = 3'd2; kind = 2'd1; base = 16'h1234; idx_x = 8'h55; idx_y = 8'h66;
      @(posedge clk); #1;
    end
    start = 1'b0;
    while (busy) begin @(posedge clk); #1; end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) zp_mem[i] = 8'(i * 37 + 11);
    zp_mem[8'h02] = 8'hF0; zp_mem[8'h03] = 8'hA3;
    zp_mem[8'h10] = 8'h00; zp_mem[8'h11] = 8'h40;
    zp_mem[8'hFF] = 8'hFE; zp_mem[8'h00] = 8'h12;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !addr_vld && !mem_req, "R9 reset idle",
          {16'b0, busy, addr_vld, mem_req}, '0);
    run(3'd0, 2'd0, 16'h00FF, 8'h01, 8'h00, "R2 abs,X read $00FF+1", 0);
    run(3'd0, 2'd0, 16'hA3F0, 8'h10, 8'h00, "R2 abs,X read $A3F0+$10", 0);
    run(3'd1, 2'd0, 16'hA3F0, 8'h77, 8'h0F, "R3 abs,Y read no cross", 0);
    run(3'd0, 2'd0, 16'hFFFF, 8'h01, 8'h00, "R1 abs,X wrap to $0000", 0);
    run(3'd1, 2'd0, 16'h2080, 8'h00, 8'h7F, "R1 abs,Y uses Y", 0);
    run(3'd2, 2'd0, 16'hA5FF, 8'h01, 8'h00, "R4 zp,X read wrap", 0);
    run(3'd3, 2'd1, 16'h0080, 8'h00, 8'h90, "R4 zp,Y write wrap", 0);
    run(3'd2, 2'd2, 16'h00F0, 8'h20, 8'h00, "R4 zp,X rmw", 0);
    run(3'd0, 2'd1, 16'h03F0, 8'h20, 8'h00, "R7 abs,X write cross", 0);
    run(3'd1, 2'd2, 16'h1200, 8'h00, 8'h05, "R7 abs,Y rmw", 0);
    run(3'd4, 2'd0, 16'h0002, 8'h00, 8'h20, "R6 ind,Y read cross", 0);
    run(3'd4, 2'd0, 16'h0010, 8'h00, 8'h7F, "R5 ind,Y read", 0);
    run(3'd4, 2'd1, 16'h00FF, 8'h00, 8'h03, "R5 R7 ind,Y write pointer wrap", 0);
    run(3'd0, 2'd0, 16'h0100, 8'h01, 8'h00, "R9 start while busy", 1);
    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R9 leftover expected beats",
          19'(exp_q.size()), '0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule